// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical address into a physical address. It uses a per-process page table with 256-byte pages. The top eight address bits select a page-table entry, and the low eight bits pass straight through as the byte offset. The entry's frame number is placed above that offset to form the physical address. Each entry holds a frame number, a presence flag and a modified flag. A lookup that lands on an absent entry signals a page fault and produces no address.

In front of the table sits a small fully associative cache of recent page-to-frame pairs. A request that finds its page there is answered on the next cycle. A request that misses spends one more cycle reading the table, and if the entry is present the pair is copied into the cache. Software loads table entries through a configuration port, which can also read back any entry. Every configuration write removes any cached copy of the page it writes. Bringing pages in from backing store and choosing which page to evict are handled elsewhere.

Top module: `paged_xlate_unit`

## Requirements
- R1: The physical address equals frame × 256 + offset. The offset is `req_addr[7:0]` and passes through unchanged, and the page is `req_addr[15:8]`. With page 1 mapped to frame 3, address 320 gives 832.
- R2: A request that misses the cache raises `rsp_valid` two clock edges after it is accepted, with `rsp_hit`=0. If the entry is present, the cache is filled, so the same page hits when it is next requested.
- R3: A request that hits the cache raises `rsp_valid` on the first edge after it is accepted, with `rsp_hit`=1.
- R4: An entry whose presence flag is 0 gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_paddr`=0. Such an entry is never cached, so a repeated request to it misses and faults again.
- R5: An accepted write request that translates without a fault sets the modified flag of its page in the table. A read request leaves the flag unchanged, and so does a write request that faults.
- R6: A configuration write to a page removes that page from the cache. The next request to that page misses and uses the newly written frame.
- R7: The cache holds 4 pages. Fills go to the slots in rotating order, starting at slot 0 after reset. A fifth distinct fill therefore evicts the first page that was filled, while the other three pages still hit.
- R8: `req_ready` is 0 during the table-read cycle of a miss and in any cycle where `cfg_we` is 1. A request presented while `req_ready` is 0 is not accepted and produces no response.
- R9: After reset, `rsp_valid` is 0, `req_ready` is 1, every table entry is absent and unmodified, and the cache is empty.
- R10: `cfg_rd_frame`, `cfg_rd_valid` and `cfg_rd_dirty` show, combinationally, the table entry selected by `cfg_page`.
- R11: Each accepted request yields exactly one response cycle. `rsp_valid` stays 0 in cycles where no response is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is present |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Logical address |
| rsp_valid | output | 1 | Response outputs are meaningful this cycle |
| rsp_hit | output | 1 | 1 = answered from the cache, 0 = from the table |
| rsp_fault | output | 1 | The selected entry is absent |
| rsp_paddr | output | 16 | Physical address; 0 on a fault |
| cfg_we | input | 1 | Write the table entry selected by `cfg_page` |
| cfg_page | input | 8 | Page number used for the configuration write and read |
| cfg_frame | input | 8 | Frame number to write |
| cfg_valid | input | 1 | Presence flag to write |
| cfg_dirty | input | 1 | Modified flag to write |
| cfg_rd_frame | output | 8 | Frame number of the entry selected by `cfg_page` |
| cfg_rd_valid | output | 1 | Presence flag of the entry selected by `cfg_page` |
| cfg_rd_dirty | output | 1 | Modified flag of the entry selected by `cfg_page` |

## Verification
The assertions assume a few things about the inputs. Requests are offered only through the ready handshake. Configuration writes arrive as separate single-cycle strobes and are never timed so that they overtake a request already in flight. Given that, after a cache invalidation no stale copy of the page remains, and a miss always answers exactly two edges after it is accepted. The bench drives every request and configuration write on the falling edge. It offers requests only while `req_ready` is high, except in the directed cases that deliberately test rejection. Random traffic uses only 16 pages and 4 cache slots, so hits, misses, evictions and faults all occur often.

// File: rtl/pat_pkg.sv
package pat_pkg;

  // Controller phase: idle accepts requests, walk reads the page table.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;

endpackage

// File: rtl/pat_page_table.sv
module pat_page_table #(
  parameter int VPN_W = 8,
  parameter int PFN_W = 8,
  localparam int DEPTH = 1 << VPN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  // configuration write
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_page,
  input  logic [PFN_W-1:0] wr_frame,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  // modified-flag set from a translated write access
  input  logic             mark_en,
  input  logic [VPN_W-1:0] mark_page,
  // lookup port for the walk
  input  logic [VPN_W-1:0] walk_page,
  output logic [PFN_W-1:0] walk_frame,
  output logic             walk_valid,
  // read-back port for configuration
  input  logic [VPN_W-1:0] rb_page,
  output logic [PFN_W-1:0] rb_frame,
  output logic             rb_valid,
  output logic             rb_dirty
);

  logic [PFN_W-1:0] frame_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] dirty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_page == VPN_W'(i))) begin
          valid_q[i] <= wr_valid;
          dirty_q[i] <= wr_dirty | (mark_en && (mark_page == VPN_W'(i)));
        end else if (mark_en && (mark_page == VPN_W'(i))) begin
          dirty_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_page == VPN_W'(i))) frame_q[i] <= wr_frame;
    end
  end

  assign walk_frame = frame_q[walk_page];
  assign walk_valid = valid_q[walk_page];
  assign rb_frame   = frame_q[rb_page];
  assign rb_valid   = valid_q[rb_page];
  assign rb_dirty   = dirty_q[rb_page];

  // R5: a mark not overridden by a configuration write leaves the flag set
  a_r5_dirty_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !(wr_en && (wr_page == mark_page))) |=> dirty_q[$past(mark_page)])
    else $error("modified flag not set after a write access");

endmodule

// File: rtl/pat_tlb.sv
module pat_tlb #(
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 8,
  parameter int ENTRIES = 4,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_page,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_frame,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_page,
  input  logic [PFN_W-1:0] fill_frame,
  input  logic             inval_en,
  input  logic [VPN_W-1:0] inval_page
);

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_page  [ENTRIES];
  logic [PFN_W-1:0]   ent_frame [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;

  function automatic logic [PTR_W-1:0] next_slot(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = ent_v[i] && (ent_page[i] == lk_page);
      if (match[i]) lk_frame = lk_frame | ent_frame[i];
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      ptr_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_page[i]  <= '0;
        ent_frame[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inval_en && ent_v[i] && (ent_page[i] == inval_page)) ent_v[i] <= 1'b0;
      end
      if (fill_en) begin
        ent_v[ptr_q]     <= 1'b1;
        ent_page[ptr_q]  <= fill_page;
        ent_frame[ptr_q] <= fill_frame;
        ptr_q            <= next_slot(ptr_q);
      end
    end
  end

  // Checker state: page just invalidated, looked for again one cycle later.
  logic               chk_pend_q;
  logic [VPN_W-1:0]   chk_page_q;
  logic [ENTRIES-1:0] stale;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_pend_q <= 1'b0;
      chk_page_q <= '0;
    end else begin
      chk_pend_q <= inval_en && !(fill_en && (fill_page == inval_page));
      chk_page_q <= inval_page;
    end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) stale[i] = ent_v[i] && (ent_page[i] == chk_page_q);
  end

  // R7: a page is cached in at most one slot
  a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match))
    else $error("page cached in more than one slot");

  // R6: an invalidated page is gone from every slot
  a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    chk_pend_q |-> (stale == '0))
    else $error("stale copy survives invalidation");

endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit import pat_pkg::*; #(
  parameter int OFF_W       = 8,
  parameter int VPN_W       = 8,
  parameter int PFN_W       = 8,
  parameter int TLB_ENTRIES = 4,
  localparam int VA_W = VPN_W + OFF_W,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  input  logic             cfg_we,
  input  logic [VPN_W-1:0] cfg_page,
  input  logic [PFN_W-1:0] cfg_frame,
  input  logic             cfg_valid,
  input  logic             cfg_dirty,
  output logic [PFN_W-1:0] cfg_rd_frame,
  output logic             cfg_rd_valid,
  output logic             cfg_rd_dirty
);

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] compose_paddr(input logic [PFN_W-1:0] f,
                                                    input logic [OFF_W-1:0] o);
    return {f, o};
  endfunction

  walk_state_e      state_q;
  logic [VA_W-1:0]  walk_addr_q;
  logic             walk_write_q;

  // named internal events
  logic             req_fire;
  logic             tlb_hit;
  logic [PFN_W-1:0] tlb_frame;
  logic             hit_fire;
  logic             miss_fire;
  logic             walk_done;
  logic [VPN_W-1:0] walk_page;
  logic [PFN_W-1:0] pt_frame;
  logic             pt_valid;
  logic             cfg_hits_walk;
  logic [PFN_W-1:0] ent_frame;
  logic             ent_valid;
  logic             tlb_fill;
  logic             mark_en;
  logic [VPN_W-1:0] mark_page;

  assign req_ready = (state_q == ST_IDLE) && !cfg_we;
  assign req_fire  = req_valid && req_ready;
  assign hit_fire  = req_fire && tlb_hit;
  assign miss_fire = req_fire && !tlb_hit;
  assign walk_done = (state_q == ST_WALK);
  assign walk_page = page_of(walk_addr_q);

  // A configuration write landing on the walked page in the same cycle wins.
  assign cfg_hits_walk = cfg_we && (cfg_page == walk_page);
  assign ent_frame     = cfg_hits_walk ? cfg_frame : pt_frame;
  assign ent_valid     = cfg_hits_walk ? cfg_valid : pt_valid;

  assign tlb_fill  = walk_done && ent_valid;
  assign mark_en   = (hit_fire && req_write) || (tlb_fill && walk_write_q);
  assign mark_page = walk_done ? walk_page : page_of(req_addr);

  pat_tlb #(
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W),
    .ENTRIES (TLB_ENTRIES)
  ) tlb_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_page    (page_of(req_addr)),
    .lk_hit     (tlb_hit),
    .lk_frame   (tlb_frame),
    .fill_en    (tlb_fill),
    .fill_page  (walk_page),
    .fill_frame (ent_frame),
    .inval_en   (cfg_we),
    .inval_page (cfg_page)
  );

  pat_page_table #(
    .VPN_W (VPN_W),
    .PFN_W (PFN_W)
  ) pt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_page    (cfg_page),
    .wr_frame   (cfg_frame),
    .wr_valid   (cfg_valid),
    .wr_dirty   (cfg_dirty),
    .mark_en    (mark_en),
    .mark_page  (mark_page),
    .walk_page  (walk_page),
    .walk_frame (pt_frame),
    .walk_valid (pt_valid),
    .rb_page    (cfg_page),
    .rb_frame   (cfg_rd_frame),
    .rb_valid   (cfg_rd_valid),
    .rb_dirty   (cfg_rd_dirty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      walk_addr_q  <= '0;
      walk_write_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (miss_fire) begin
          state_q      <= ST_WALK;
          walk_addr_q  <= req_addr;
          walk_write_q <= req_write;
        end
        ST_WALK: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= hit_fire || walk_done;
      if (hit_fire) begin
        rsp_hit   <= 1'b1;
        rsp_fault <= 1'b0;
        rsp_paddr <= compose_paddr(tlb_frame, offset_of(req_addr));
      end else if (walk_done) begin
        rsp_hit   <= 1'b0;
        rsp_fault <= !ent_valid;
        rsp_paddr <= ent_valid ? compose_paddr(ent_frame, offset_of(walk_addr_q)) : '0;
      end else begin
        rsp_hit   <= 1'b0;
        rsp_fault <= 1'b0;
        rsp_paddr <= '0;
      end
    end
  end

  // R3: a hit answers on the next edge from the cache
  a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_valid && rsp_hit && !rsp_fault))
    else $error("hit not answered one cycle later");

  // R2: a miss stays silent for one cycle, then answers from the table
  a_r2_miss_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> (!rsp_valid ##1 (rsp_valid && !rsp_hit)))
    else $error("miss not answered two cycles later");

  // R4: a fault carries no address and no hit
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_hit && (rsp_paddr == '0)))
    else $error("fault response carries an address");

  // R1: the offset passes through a hit unchanged
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> (rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0])))
    else $error("offset altered by translation");

  // R8: nothing is accepted while the walk is in progress
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !req_fire)
    else $error("request accepted during walk");

endmodule

// File: tb/paged_xlate_unit_tb_top.sv
module paged_xlate_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [15:0] rsp_paddr;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_page = '0;
  logic [7:0]  cfg_frame = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_dirty = 1'b0;
  logic [7:0]  cfg_rd_frame;
  logic        cfg_rd_valid, cfg_rd_dirty;

  always #5 clk = ~clk;

  paged_xlate_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_frame(cfg_frame),
    .cfg_valid(cfg_valid), .cfg_dirty(cfg_dirty),
    .cfg_rd_frame(cfg_rd_frame), .cfg_rd_valid(cfg_rd_valid), .cfg_rd_dirty(cfg_rd_dirty)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference state
  int m_frame [256];
  bit m_valid [256];
  bit m_dirty [256];
  int t_page  [4];
  bit t_v     [4];
  int t_ptr = 0;

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int exp_paddr(input int frame, input int addr);
    return frame * 256 + (addr % 256);
  endfunction

  function automatic bit model_hit(input int page);
    for (int i = 0; i < 4; i++) if (t_v[i] && t_page[i] == page) return 1;
    return 0;
  endfunction

  function automatic void model_fill(input int page);
    t_page[t_ptr] = page;
    t_v[t_ptr] = 1;
    t_ptr = (t_ptr + 1) % 4;
  endfunction

  function automatic void model_cfg(input int page, input int frame, input bit v, input bit d);
    m_frame[page] = frame;
    m_valid[page] = v;
    m_dirty[page] = d;
    for (int i = 0; i < 4; i++) if (t_v[i] && t_page[i] == page) t_v[i] = 0;
  endfunction

  task automatic cfg_write(input int page, input int frame, input bit v, input bit d);
    @(negedge clk);
    cfg_we = 1; cfg_page = page[7:0]; cfg_frame = frame[7:0]; cfg_valid = v; cfg_dirty = d;
    @(negedge clk);
    cfg_we = 0;
    model_cfg(page, frame, v, d);
  endtask

  task automatic read_entry(input int page, input string rq);
    @(negedge clk);
    cfg_page = page[7:0];
    #1;
    chk(rq, "rd_valid", cfg_rd_valid, m_valid[page]);
    chk(rq, "rd_dirty", cfg_rd_dirty, m_dirty[page]);
    if (m_valid[page]) chk(rq, "rd_frame", cfg_rd_frame, m_frame[page]);
  endtask

  // issue one request and check it; returns whether it was a cache hit
  task automatic do_req(input int addr, input bit wr, input string rq, output bit was_hit);
    int page;
    bit hit;
    page = addr / 256;
    hit = model_hit(page);
    was_hit = hit;
    @(negedge clk);
    chk(rq, "ready_before", req_ready, 1);
    req_valid = 1; req_addr = addr[15:0]; req_write = wr;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    if (hit) begin
      chk(rq, "hit_valid", rsp_valid, 1);
      chk(rq, "hit_flag", rsp_hit, 1);
      chk(rq, "hit_fault", rsp_fault, 0);
      chk(rq, "hit_paddr", rsp_paddr, exp_paddr(m_frame[page], addr));
      if (wr) m_dirty[page] = 1;
    end else begin
      chk(rq, "miss_early", rsp_valid, 0);
      @(negedge clk);
      chk(rq, "miss_valid", rsp_valid, 1);
      chk(rq, "miss_flag", rsp_hit, 0);
      if (m_valid[page]) begin
        chk(rq, "miss_fault", rsp_fault, 0);
        chk(rq, "miss_paddr", rsp_paddr, exp_paddr(m_frame[page], addr));
        model_fill(page);
        if (wr) m_dirty[page] = 1;
      end else begin
        chk(rq, "fault_flag", rsp_fault, 1);
        chk(rq, "fault_paddr", rsp_paddr, 0);
      end
    end
    @(negedge clk);
    chk("R11", "no_extra_rsp", rsp_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit h;
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) begin m_frame[i] = 0; m_valid[i] = 0; m_dirty[i] = 0; end
    for (int i = 0; i < 4; i++) begin t_page[i] = 0; t_v[i] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9: reset state
    #1;
    chk("R9", "rsp_valid", rsp_valid, 0);
    chk("R9", "req_ready", req_ready, 1);
    read_entry(1, "R9");
    read_entry(200, "R9");

    cfg_write(0, 1, 1, 0);
    cfg_write(1, 3, 1, 0);
    cfg_write(2, 2, 1, 0);
    cfg_write(3, 0, 0, 0);
    read_entry(1, "R10");

    // R1 / R2: address 320 -> 832 via a miss, then R3 hit
    do_req(320, 0, "R2", h);
    chk("R1", "paddr_320", rsp_paddr, 0);
    do_req(320, 0, "R3", h);
    chk("R3", "was_hit", h, 1);
    do_req(1 * 256 + 255, 0, "R1", h);

    // R4: absent entry faults and is not cached
    do_req(3 * 256 + 7, 0, "R4", h);
    do_req(3 * 256 + 7, 0, "R4", h);
    chk("R4", "refault_miss", h, 0);
    do_req(3 * 256 + 9, 1, "R5", h);
    read_entry(3, "R5");

    // R5: write sets the modified flag, read does not
    do_req(2 * 256 + 4, 1, "R5", h);
    read_entry(2, "R5");
    do_req(0 * 256 + 4, 0, "R5", h);
    read_entry(0, "R5");
    do_req(0 * 256 + 5, 1, "R5", h);
    read_entry(0, "R5");

    // R6: remap page 1 while cached
    cfg_write(1, 7, 1, 0);
    do_req(320, 0, "R6", h);
    chk("R6", "remap_miss", h, 0);
    chk("R6", "remap_paddr", rsp_paddr, 0);

    // R7: rotating replacement over 5 distinct pages
    for (int p = 10; p < 15; p++) cfg_write(p, p + 100, 1, 0);
    for (int p = 10; p < 15; p++) do_req(p * 256 + p, 0, "R7", h);
    do_req(12 * 256, 0, "R7", h);
    chk("R7", "survivor_hit", h, 1);
    do_req(10 * 256, 0, "R7", h);
    chk("R7", "evicted_miss", h, 0);

    // R8: requests during a walk or a configuration write are refused
    cfg_write(20, 5, 1, 0);
    @(negedge clk);
    req_valid = 1; req_addr = 16'(20 * 256 + 3); req_write = 0;
    @(negedge clk);
    req_addr = 16'(0 * 256 + 1);
    #1;
    chk("R8", "ready_in_walk", req_ready, 0);
    @(negedge clk);
    req_valid = 0;
    chk("R8", "walk_rsp", rsp_valid, 1);
    chk("R8", "walk_paddr", rsp_paddr, exp_paddr(5, 3));
    model_fill(20);
    @(negedge clk);
    chk("R8", "refused_no_rsp", rsp_valid, 0);
    cfg_we = 1; cfg_page = 40; cfg_frame = 9; cfg_valid = 1; cfg_dirty = 0;
    req_valid = 1; req_addr = 16'(0 * 256 + 2); req_write = 1;
    #1;
    chk("R8", "ready_in_cfg", req_ready, 0);
    @(negedge clk);
    cfg_we = 0; req_valid = 0; req_write = 0;
    model_cfg(40, 9, 1, 0);
    chk("R8", "cfg_block_no_rsp", rsp_valid, 0);
    @(negedge clk);
    chk("R8", "cfg_block_no_rsp2", rsp_valid, 0);
    read_entry(0, "R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r, pg;
      r = $urandom % 100;
      pg = $urandom % 16;
      if (r < 15) cfg_write(pg, $urandom % 256, ($urandom % 5) != 0, $urandom % 2);
      else if (r < 25) read_entry(pg, "R10");
      else do_req(pg * 256 + ($urandom % 256), $urandom % 2, "R1", h);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule